// File: doc/BRIEF.md
# Three-Wire Serial Master with Four Selects

This block is a polled serial master for simple three-wire peripherals (a clock, a data output and a data input), with four chip-select lines. Software reaches it through a 16-bit register bus with five word registers: the data word, a command and status word, two setup words that each hold the settings of two selects, and a clock word. A transfer shifts a programmable number of bits out of the data word, most significant first. It may then shift a programmable number of bits back in with no gap. The incoming bits are collected right-aligned.

Every select has its own settings: the edge on which output data changes, the edge on which input data is sampled, the level at which the select line counts as active, and a bit-rate divider. A shared prescaler feeds all four selects, and a clock-enable bit gates it. The select lines are driven by explicit commands, separate from the transfer start. Software writes a command, then polls the busy flag until it clears, and polls the read-ready flag before it fetches received data.

Top module: `mw_serial_master`

## Requirements
- R1: After reset every register reads zero, busy (command word bit 14) and read-ready (bit 15) are clear, `ser_clk` and `ser_dout` are low, and every `sel_out` line is high, because level 0 is active-low.
- R2: The register offsets are 0 data, 1 command, 2 setup for selects 0 and 1, 3 setup for selects 2 and 3, and 4 clock. The command word holds the read count in bits 4:0, the write count in bits 9:5, the select index in bits 11:10 and the select command bit in bit 12, and these four fields read back as written. The clock word keeps bits 2:0 and reads zero above them. A setup word keeps bits 4:0 and 10:6 and reads zero elsewhere.
- R3: A command write with bit 13 (start) clear sets busy. On the next prescaler tick, the indexed select becomes active if bit 12 is 1 or inactive if bit 12 is 0, and busy clears at that point.
- R4: A transfer sends its write-count bits from the data word, starting at bit 15 and moving down one bit at a time, and produces exactly write-count plus read-count rising edges on `ser_clk`.
- R5: The received bits form a right-aligned word, with the first received bit most significant. Read-ready sets in the cycle the transfer ends and clears when offset 0 is read.
- R6: A transfer whose read count is zero leaves read-ready clear.
- R7: In a setup field, bit 1 set makes output bits change when `ser_clk` falls (and before the first bit), so a peripheral samples them on the rise; bit 1 clear makes them change on the rise, to be sampled on the fall. Bit 0 set samples `ser_din` on the fall; bit 0 clear samples it on the rise.
- R8: `ser_clk` stays low whenever the block is not busy. During a transfer, its period in system clocks equals the prescale (clock word bits 2:1: 0 gives 2, 1 gives 4, 2 gives 7, 3 gives 10) multiplied by the select divider (setup bits 4:3: 0 gives 2, 1 gives 4, 2 or 3 gives 8).
- R9: While clock word bit 0 is clear, a command write has no effect: busy stays clear, the selects do not change, `ser_clk` does not toggle, and the command fields are not stored.
- R10: A command write that arrives while busy is set is ignored as a whole.
- R11: A start with bit 12 set makes the indexed select active before its first clock edge, and the select stays active after the transfer. A start with both counts zero acts as a select command.
- R12: Bit 2 of a setup field is the active level of that select. Even selects use bits 5:0 of their setup word and odd selects use bits 11:6. Selects 0 and 1 use offset 2, and selects 2 and 3 use offset 3. An inactive select drives the inverse of its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading offset 0 clears read-ready) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational on `bus_addr` |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dout | output | 1 | Serial data to the peripheral |
| ser_din | input | 1 | Serial data from the peripheral |
| sel_out | output | 4 | Select lines, at the configured level when active |

## Verification
The bench models a peripheral that samples `ser_dout` on the edge opposite to the configured launch edge and drives `ser_din` after each falling edge. It randomises the edges, dividers, counts and data on every select. A design that mixed up the launch or sample edge would hand the model shifted or stale bits. Reversing the order of the incoming bits would show up in the received word. An engine that dropped or added a bit would show a wrong count of clock edges. Directed cases cover the clock-enable gate, a command written during a transfer, a zero read count, the odd-select field offset and the period with the ten-way prescale. A design that leaked one of these would change a select line, overwrite stored fields, raise read-ready or produce the wrong rise-to-rise spacing.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [1:0] {
      MW_IDLE   = 2'd0,
      MW_SELCHG = 2'd1,
      MW_XFER   = 2'd2
   } mw_state_e;

   // per-select settings, packed to match the 5 stored bits of a setup field
   typedef struct packed {
      logic [1:0] div;      // half-period length in prescaler ticks
      logic       lvl;      // active level of the select line
      logic       wr_fall;  // output bits change on the falling edge
      logic       rd_fall;  // input bits sampled on the falling edge
   } mw_sel_cfg_t;

   // last count value of one serial half period, in prescaler ticks
   function automatic logic [1:0] half_last(input logic [1:0] div);
      case (div)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

   // last count value of the prescaler for a given setting
   function automatic logic [3:0] pre_last(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd1;
         2'd1:    return 4'd3;
         2'd2:    return 4'd6;
         default: return 4'd9;
      endcase
   endfunction

endpackage

// File: rtl/mw_prescaler.sv
module mw_prescaler #(
   parameter int CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] code,
   output logic       tick
);
   import mw_pkg::*;

   if (CNT_W < 4) begin : g_bad_width
      $error("mw_prescaler: CNT_W must hold a count of 9");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   assign lim  = CNT_W'(pre_last(code));
   assign tick = en && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!en)        cnt_q <= '0;
      else if (cnt_q >= lim) cnt_q <= '0;
      else                 cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/mw_select_bank.sv
module mw_select_bank #(
   parameter int NSEL   = 4,
   parameter int CFG_W  = 6,
   parameter int DATA_W = 16,
   localparam int NREG  = NSEL / 2,
   localparam int FW    = $bits(mw_pkg::mw_sel_cfg_t),
   localparam int IDX_W = $clog2(NSEL)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREG-1:0]             wr_stb,
   input  logic [1:0][FW-1:0]          wfield,
   input  logic [NSEL-1:0]             act,
   input  logic [IDX_W-1:0]            pick,
   output logic [NREG-1:0][DATA_W-1:0] rd_word,
   output logic [NSEL-1:0]             sel_out,
   output logic [1:0]                  pick_div,
   output logic                        pick_wr_fall,
   output logic                        pick_rd_fall
);
   import mw_pkg::*;

   if (CFG_W < FW || 2 * CFG_W > DATA_W || NSEL % 2 != 0) begin : g_bad_layout
      $error("mw_select_bank: setup fields do not fit the register");
   end

   mw_sel_cfg_t cfg_q [NSEL];

   for (genvar i = 0; i < NSEL; i++) begin : g_sel
      localparam int REG  = i / 2;
      localparam int HALF = i % 2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cfg_q[i] <= '0;
         else if (wr_stb[REG]) cfg_q[i] <= mw_sel_cfg_t'(wfield[HALF]);
      end
      assign sel_out[i] = act[i] ? cfg_q[i].lvl : ~cfg_q[i].lvl;
   end

   for (genvar r = 0; r < NREG; r++) begin : g_rd
      always_comb begin
         rd_word[r]               = '0;
         rd_word[r][FW-1:0]       = cfg_q[2*r];
         rd_word[r][CFG_W +: FW]  = cfg_q[2*r+1];
      end
   end

   mw_sel_cfg_t picked;
   assign picked       = cfg_q[pick];
   assign pick_div     = picked.div;
   assign pick_wr_fall = picked.wr_fall;
   assign pick_rd_fall = picked.rd_fall;

endmodule

// File: rtl/mw_shift_engine.sv
module mw_shift_engine #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 5,
   localparam int TOT_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic [CNT_W-1:0]  wr_bits,
   input  logic [CNT_W-1:0]  rd_bits,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [1:0]        cfg_div,
   input  logic              cfg_wr_fall,
   input  logic              cfg_rd_fall,
   input  logic              sdi,
   output logic              done,
   output logic              sclk,
   output logic              sdo,
   output logic [DATA_W-1:0] rx_word
);
   import mw_pkg::*;

   logic              active_q, ph_q;
   logic [1:0]        hc_q, div_q;
   logic              wf_q, rf_q;
   logic [TOT_W-1:0]  bc_q, last_q;
   logic [CNT_W-1:0]  wn_q;
   logic [DATA_W-1:0] sh_q, rx_q;
   logic              sclk_q, sdo_q;

   logic half_end, in_rd, more_wr;

   assign half_end = active_q && tick && (hc_q == half_last(div_q));
   assign in_rd    = bc_q >= TOT_W'(wn_q);
   assign more_wr  = (bc_q + TOT_W'(1)) < TOT_W'(wn_q);
   assign done     = half_end && ph_q && (bc_q == last_q);

   assign sclk    = sclk_q;
   assign sdo     = sdo_q;
   assign rx_word = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ph_q     <= 1'b0;
         hc_q     <= '0;
         div_q    <= '0;
         wf_q     <= 1'b0;
         rf_q     <= 1'b0;
         bc_q     <= '0;
         last_q   <= '0;
         wn_q     <= '0;
         sh_q     <= '0;
         rx_q     <= '0;
         sclk_q   <= 1'b0;
         sdo_q    <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         ph_q     <= 1'b0;
         hc_q     <= '0;
         div_q    <= cfg_div;
         wf_q     <= cfg_wr_fall;
         rf_q     <= cfg_rd_fall;
         bc_q     <= '0;
         last_q   <= TOT_W'(wr_bits) + TOT_W'(rd_bits) - TOT_W'(1);
         wn_q     <= wr_bits;
         rx_q     <= '0;
         sclk_q   <= 1'b0;
         if (cfg_wr_fall && wr_bits != '0) begin
            sdo_q <= tx_word[DATA_W-1];
            sh_q  <= tx_word << 1;
         end else begin
            sh_q  <= tx_word;
         end
      end else if (active_q && tick) begin
         if (half_end) begin
            hc_q <= '0;
            if (!ph_q) begin
               // mid-bit: clock rises
               ph_q   <= 1'b1;
               sclk_q <= 1'b1;
               if (!wf_q && !in_rd) begin
                  sdo_q <= sh_q[DATA_W-1];
                  sh_q  <= sh_q << 1;
               end
               if (!rf_q && in_rd) rx_q <= {rx_q[DATA_W-2:0], sdi};
            end else begin
               // end of bit: clock falls
               ph_q   <= 1'b0;
               sclk_q <= 1'b0;
               if (rf_q && in_rd) rx_q <= {rx_q[DATA_W-2:0], sdi};
               if (bc_q == last_q) begin
                  active_q <= 1'b0;
               end else begin
                  bc_q <= bc_q + TOT_W'(1);
                  if (wf_q && more_wr) begin
                     sdo_q <= sh_q[DATA_W-1];
                     sh_q  <= sh_q << 1;
                  end
               end
            end
         end else begin
            hc_q <= hc_q + 2'd1;
         end
      end
   end

endmodule

// File: rtl/mw_serial_master.sv
module mw_serial_master #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 5,
   parameter int NSEL   = 4,
   parameter int CFG_W  = 6,
   parameter int PRE_W  = 4,
   localparam int IDX_W     = $clog2(NSEL),
   localparam int NREG      = NSEL / 2,
   localparam int FW        = $bits(mw_pkg::mw_sel_cfg_t),
   localparam int WC_LSB    = CNT_W,
   localparam int IDX_LSB   = 2 * CNT_W,
   localparam int CMD_BIT   = IDX_LSB + IDX_W,
   localparam int START_BIT = CMD_BIT + 1,
   localparam int BUSY_BIT  = START_BIT + 1,
   localparam int RDY_BIT   = BUSY_BIT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ser_clk,
   output logic              ser_dout,
   input  logic              ser_din,
   output logic [NSEL-1:0]   sel_out
);
   import mw_pkg::*;

   if (RDY_BIT != DATA_W - 1 || NSEL != 4) begin : g_bad_map
      $error("mw_serial_master: command word layout does not fill the bus");
   end

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_CMD  = 3'd1;
   localparam logic [2:0] A_SET0 = 3'd2;
   localparam logic [2:0] A_SET1 = 3'd3;
   localparam logic [2:0] A_CLK  = 3'd4;

   // stored registers
   logic [DATA_W-1:0] tx_q;
   logic [CNT_W-1:0]  rcnt_q, wcnt_q;
   logic [IDX_W-1:0]  idx_q, pend_idx_q;
   logic              cmd_q, pend_val_q;
   logic              clk_en_q;
   logic [1:0]        pre_code_q;
   logic              rdy_q;
   logic [NSEL-1:0]   act_q;
   mw_state_e         state_q;

   // command decode
   logic [CNT_W-1:0] w_rcnt, w_wcnt;
   logic [IDX_W-1:0] w_idx;
   logic             w_cmd, w_start, accept, go_xfer, go_sel, busy;

   assign w_rcnt  = bus_wdata[CNT_W-1:0];
   assign w_wcnt  = bus_wdata[WC_LSB +: CNT_W];
   assign w_idx   = bus_wdata[IDX_LSB +: IDX_W];
   assign w_cmd   = bus_wdata[CMD_BIT];
   assign w_start = bus_wdata[START_BIT] && ((w_rcnt != '0) || (w_wcnt != '0));
   assign busy    = (state_q != MW_IDLE);
   assign accept  = bus_wr && (bus_addr == A_CMD) && !busy && clk_en_q;
   assign go_xfer = accept && w_start;
   assign go_sel  = accept && !w_start;

   // prescaler
   logic tick;
   mw_prescaler #(.CNT_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (clk_en_q),
      .code  (pre_code_q),
      .tick  (tick)
   );

   // per-select settings and select lines
   logic [NREG-1:0]             set_stb;
   logic [1:0][FW-1:0]          set_field;
   logic [NREG-1:0][DATA_W-1:0] set_word;
   logic [1:0]                  pk_div;
   logic                        pk_wf, pk_rf;

   assign set_stb[0]   = bus_wr && (bus_addr == A_SET0);
   assign set_stb[1]   = bus_wr && (bus_addr == A_SET1);
   assign set_field[0] = bus_wdata[FW-1:0];
   assign set_field[1] = bus_wdata[CFG_W +: FW];

   mw_select_bank #(.NSEL(NSEL), .CFG_W(CFG_W), .DATA_W(DATA_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_stb       (set_stb),
      .wfield       (set_field),
      .act          (act_q),
      .pick         (w_idx),
      .rd_word      (set_word),
      .sel_out      (sel_out),
      .pick_div     (pk_div),
      .pick_wr_fall (pk_wf),
      .pick_rd_fall (pk_rf)
   );

   // shift engine
   logic              eng_done;
   logic [DATA_W-1:0] rx_word;

   mw_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .start       (go_xfer),
      .wr_bits     (w_wcnt),
      .rd_bits     (w_rcnt),
      .tx_word     (tx_q),
      .cfg_div     (pk_div),
      .cfg_wr_fall (pk_wf),
      .cfg_rd_fall (pk_rf),
      .sdi         (ser_din),
      .done        (eng_done),
      .sclk        (ser_clk),
      .sdo         (ser_dout),
      .rx_word     (rx_word)
   );

   // control state and register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q       <= '0;
         rcnt_q     <= '0;
         wcnt_q     <= '0;
         idx_q      <= '0;
         cmd_q      <= 1'b0;
         pend_idx_q <= '0;
         pend_val_q <= 1'b0;
         clk_en_q   <= 1'b0;
         pre_code_q <= '0;
         rdy_q      <= 1'b0;
         act_q      <= '0;
         state_q    <= MW_IDLE;
      end else begin
         if (bus_wr && bus_addr == A_DATA) tx_q <= bus_wdata;
         if (bus_wr && bus_addr == A_CLK) begin
            clk_en_q   <= bus_wdata[0];
            pre_code_q <= bus_wdata[2:1];
         end
         if (bus_rd && bus_addr == A_DATA) rdy_q <= 1'b0;

         if (accept) begin
            rcnt_q <= w_rcnt;
            wcnt_q <= w_wcnt;
            idx_q  <= w_idx;
            cmd_q  <= w_cmd;
         end

         case (state_q)
            MW_IDLE: begin
               if (go_xfer) begin
                  state_q <= MW_XFER;
                  if (w_cmd) act_q[w_idx] <= 1'b1;
                  if (w_rcnt != '0) rdy_q <= 1'b0;
               end else if (go_sel) begin
                  state_q    <= MW_SELCHG;
                  pend_idx_q <= w_idx;
                  pend_val_q <= w_cmd;
               end
            end
            MW_SELCHG: begin
               if (tick) begin
                  act_q[pend_idx_q] <= pend_val_q;
                  state_q           <= MW_IDLE;
               end
            end
            MW_XFER: begin
               if (eng_done) begin
                  state_q <= MW_IDLE;
                  if (rcnt_q != '0) rdy_q <= 1'b1;
               end
            end
            default: state_q <= MW_IDLE;
         endcase
      end
   end

   // register read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_DATA: bus_rdata = rx_word;
         A_CMD: begin
            bus_rdata[CNT_W-1:0]         = rcnt_q;
            bus_rdata[WC_LSB +: CNT_W]   = wcnt_q;
            bus_rdata[IDX_LSB +: IDX_W]  = idx_q;
            bus_rdata[CMD_BIT]           = cmd_q;
            bus_rdata[BUSY_BIT]          = busy;
            bus_rdata[RDY_BIT]           = rdy_q;
         end
         A_SET0: bus_rdata = set_word[0];
         A_SET1: bus_rdata = set_word[1];
         A_CLK:  bus_rdata[2:0] = {pre_code_q, clk_en_q};
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mw_checker.sv
module mw_checker #(
   parameter int NSEL = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            rdy,
   input logic            sclk,
   input logic            bus_wr,
   input logic            bus_rd,
   input logic [2:0]      bus_addr,
   input logic [NSEL-1:0] sel_out
);

   // R8: the serial clock rests low outside a command
   a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R8: a rising serial clock only occurs inside a command
   a_r8_rise_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> busy);

   // R5: read-ready only rises at the end of a transfer
   a_r5_rdy_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $fell(busy));

   // R5: reading the data word clears read-ready unless a transfer just ended
   a_r5_rdy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_rd) && ($past(bus_addr) == 3'd0) && !$fell(busy)) |-> !rdy);

   // R3: with no command finishing and no register write, select lines hold
   a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $past(!bus_wr)) |-> $stable(sel_out));

endmodule

bind mw_serial_master mw_checker #(.NSEL(NSEL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rdy      (rdy_q),
   .sclk     (ser_clk),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .sel_out  (sel_out)
);

// File: tb/mw_serial_master_bench.sv
`timescale 1ns/1ps
module mw_serial_master_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ser_clk, ser_dout;
   logic        ser_din = 1'b0;
   logic [3:0]  sel_out;

   always #10 clk = ~clk;

   mw_serial_master u_mw_serial_master (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din),
      .sel_out(sel_out)
   );

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // bench model of the settings and the select states
   logic [4:0] cfg_m [4];
   logic [3:0] act_m;

   // peripheral model state
   int          cur_w = 0, cur_r = 0, cur_sel = 0;
   logic        cur_wfall = 1'b0;
   logic [15:0] cur_rpat = '0;
   logic [31:0] cap = '0;
   int          rises = 0, falls = 0;
   int          rise_cyc [2];
   logic        sel_first = 1'b0;
   logic        sclk_prev = 1'b0;

   always @(negedge clk) begin
      int idx;
      if (ser_clk && !sclk_prev) begin
         if (cur_wfall && rises < cur_w) cap[rises] = ser_dout;
         if (rises < 2) rise_cyc[rises] = cyc;
         if (rises == 0) sel_first = sel_out[cur_sel];
         rises = rises + 1;
      end
      if (!ser_clk && sclk_prev) begin
         if (!cur_wfall && falls < cur_w) cap[falls] = ser_dout;
         falls = falls + 1;
      end
      sclk_prev = ser_clk;
      idx = falls - cur_w;
      if (idx >= 0 && idx < cur_r) ser_din = cur_rpat[cur_r-1-idx];
      else ser_din = 1'b0;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic logic [15:0] ctrl_word(input logic cmd, input logic st,
         input int idx, input int w, input int r);
      return {2'b00, st, cmd, 2'(idx), 5'(w), 5'(r)};
   endfunction

   function automatic logic [3:0] exp_sel();
      logic [3:0] e;
      for (int i = 0; i < 4; i++) e[i] = act_m[i] ? cfg_m[i][2] : ~cfg_m[i][2];
      return e;
   endfunction

   function automatic logic [31:0] exp_cap(input logic [15:0] tx, input int w);
      logic [31:0] e = '0;
      for (int i = 0; i < w; i++) e[i] = (i < 16) ? tx[15-i] : 1'b0;
      return e;
   endfunction

   task automatic set_sel(input int s, input logic rf, input logic wf,
         input logic lvl, input logic [1:0] dv);
      cfg_m[s] = {dv, lvl, wf, rf};
      if (s < 2) bus_write(3'd2, {5'b0, cfg_m[1], 1'b0, cfg_m[0]});
      else       bus_write(3'd3, {5'b0, cfg_m[3], 1'b0, cfg_m[2]});
   endtask

   task automatic wait_idle(input string tag);
      logic [15:0] v;
      for (int n = 0; n < 4000; n++) begin
         bus_read(3'd1, v);
         if (!v[14]) return;
      end
      chk({tag, " busy never cleared"}, 32'd1, 32'd0);
   endtask

   task automatic sel_cmd(input int s, input logic val);
      bus_write(3'd1, ctrl_word(val, 1'b0, s, 0, 0));
      wait_idle("R3");
      act_m[s] = val;
      chk("R3 select line after command", 32'(sel_out), 32'(exp_sel()));
   endtask

   task automatic xfer(input int s, input int w, input int r, input logic [15:0] tx,
         input logic [15:0] rp, input logic cmd);
      logic [15:0] v;
      logic [15:0] mask;
      cur_sel = s; cur_w = w; cur_r = r; cur_rpat = rp; cur_wfall = cfg_m[s][1];
      cap = '0; rises = 0; falls = 0;
      bus_write(3'd0, tx);
      bus_write(3'd1, ctrl_word(cmd, 1'b1, s, w, r));
      wait_idle("R4");
      chk("R4/R7 bits seen by peripheral", cap, exp_cap(tx, w));
      chk("R4 clock rise count", 32'(rises), 32'(w + r));
      chk("R8 clock low after transfer", 32'(ser_clk), 32'd0);
      if (cmd) begin
         act_m[s] = 1'b1;
         chk("R11 select active at first edge", 32'(sel_first), 32'(cfg_m[s][2]));
      end
      chk("R11 select lines after transfer", 32'(sel_out), 32'(exp_sel()));
      bus_read(3'd1, v);
      if (r > 0) begin
         chk("R5 read-ready set", 32'(v[15]), 32'd1);
         mask = (r >= 16) ? 16'hFFFF : 16'((32'd1 << r) - 1);
         bus_read(3'd0, v);
         chk("R5/R7 received word", 32'(v), 32'(rp & mask));
         bus_read(3'd1, v);
         chk("R5 read-ready cleared by data read", 32'(v[15]), 32'd0);
      end else begin
         chk("R6 read-ready stays clear", 32'(v[15]), 32'd0);
      end
   endtask

   task automatic run_all();
      logic [15:0] v;
      for (int i = 0; i < 4; i++) cfg_m[i] = '0;
      act_m = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      bus_read(3'd1, v); chk("R1 command word", 32'(v), 32'd0);
      bus_read(3'd2, v); chk("R1 setup word 0", 32'(v), 32'd0);
      bus_read(3'd4, v); chk("R1 clock word", 32'(v), 32'd0);
      chk("R1 select lines", 32'(sel_out), 32'hF);
      chk("R1 serial outputs", {30'd0, ser_clk, ser_dout}, 32'd0);

      // R9 clock disabled: commands ignored
      bus_write(3'd1, ctrl_word(1'b1, 1'b0, 0, 0, 0));
      bus_read(3'd1, v); chk("R9 no busy, fields not stored", 32'(v), 32'd0);
      chk("R9 select unchanged", 32'(sel_out), 32'hF);
      rises = 0;
      bus_write(3'd0, 16'hA5A5);
      bus_write(3'd1, ctrl_word(1'b0, 1'b1, 0, 4, 0));
      repeat (60) @(negedge clk);
      chk("R9 no serial clock", 32'(rises), 32'd0);

      // R2 readback
      bus_write(3'd4, 16'hFFF9);
      bus_read(3'd4, v); chk("R2 clock word keeps bits 2:0", 32'(v), 32'h0001);
      bus_write(3'd2, 16'hFFFF);
      bus_read(3'd2, v); chk("R2 setup word masks", 32'(v), 32'h07DF);
      bus_write(3'd2, 16'h0000);
      bus_write(3'd1, ctrl_word(1'b1, 1'b0, 1, 9, 3));
      bus_read(3'd1, v); chk("R3 busy right after command", 32'(v[14]), 32'd1);
      wait_idle("R3");
      act_m[1] = 1'b1;
      bus_read(3'd1, v);
      chk("R2 command fields", 32'(v), 32'(ctrl_word(1'b1, 1'b0, 1, 9, 3)));
      chk("R3 select 1 active low", 32'(sel_out), 32'(exp_sel()));
      sel_cmd(1, 1'b0);

      // R12 odd select field and second setup word
      set_sel(1, 1'b0, 1'b0, 1'b1, 2'd0);
      chk("R12 odd field at bit 6", 32'(sel_out), 32'(exp_sel()));
      set_sel(3, 1'b0, 1'b0, 1'b1, 2'd0);
      chk("R12 select 3 in second word", 32'(sel_out), 32'b0101);
      set_sel(2, 1'b1, 1'b1, 1'b1, 2'd1);
      sel_cmd(2, 1'b1);
      chk("R12 active-high select 2", 32'(sel_out[2]), 32'd1);
      sel_cmd(2, 1'b0);

      // R4/R11: nine-bit write, select asserted by the start
      set_sel(0, 1'b0, 1'b1, 1'b0, 2'd0);
      xfer(0, 9, 0, 16'h1F5 << 7, 16'h0, 1'b1);
      sel_cmd(0, 1'b0);

      // R7 rising-edge launch, falling-edge sample, with read-back
      set_sel(1, 1'b1, 1'b0, 1'b0, 2'd1);
      xfer(1, 7, 11, 16'hB300, 16'h05A3, 1'b0);

      // R10 command during a transfer is dropped
      cur_sel = 2; cur_w = 12; cur_r = 4; cur_rpat = 16'h9; cur_wfall = cfg_m[2][1];
      cap = '0; rises = 0; falls = 0;
      bus_write(3'd0, 16'hC3C3);
      bus_write(3'd1, ctrl_word(1'b0, 1'b1, 2, 12, 4));
      bus_write(3'd1, ctrl_word(1'b1, 1'b0, 3, 1, 1));
      wait_idle("R10");
      chk("R10 transfer bit count intact", 32'(rises), 32'd16);
      chk("R10 select 3 not touched", 32'(sel_out), 32'(exp_sel()));
      bus_read(3'd1, v);
      chk("R10 stored fields from first command", 32'(v[12:0]),
          32'(ctrl_word(1'b0, 1'b0, 2, 12, 4)));
      bus_read(3'd0, v);
      chk("R5 four-bit receive", 32'(v), 32'h9);

      // R8 period with ten-way prescale and four-way divider
      bus_write(3'd4, 16'h0007);
      set_sel(0, 1'b0, 1'b0, 1'b0, 2'd1);
      xfer(0, 3, 0, 16'h6000, 16'h0, 1'b0);
      chk("R8 rise-to-rise period", 32'(rise_cyc[1] - rise_cyc[0]), 32'd40);
      bus_write(3'd4, 16'h0003);
      set_sel(3, 1'b1, 1'b0, 1'b1, 2'd0);
      xfer(3, 2, 2, 16'h8000, 16'h2, 1'b0);
      chk("R8 rise-to-rise period short", 32'(rise_cyc[1] - rise_cyc[0]), 32'd8);

      // constrained random transfers
      void'($urandom(32'h5EED1234));
      for (int it = 0; it < 24; it++) begin
         int s;
         logic cmd;
         s = int'($urandom_range(0, 3));
         bus_write(3'd4, {13'd0, 2'($urandom_range(0, 1)), 1'b1});
         set_sel(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 2'($urandom_range(0, 2)));
         cmd = 1'($urandom_range(0, 1));
         xfer(s, int'($urandom_range(1, 16)), int'($urandom_range(0, 16)),
              16'($urandom), 16'($urandom), cmd);
         if ($urandom_range(0, 2) == 0) sel_cmd(s, 1'b0);
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (190000) @(posedge clk);
            vectors++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule